// File: doc/BRIEF.md
# Peripheral Access Gate for a System-to-Peripheral Bus Bridge

This block sits at the slave side of a bridge from a system bus to a simple peripheral bus that serves sixteen peripheral slots. Each request names a target slot through a fixed field of its address. The gate checks the request against two per-slot policy registers before any peripheral sees it. The width-lock register holds one bit per slot. When a slot's bit is set, that slot takes only accesses of its natural width, and each slot's natural width is fixed by a parameter. The privilege-lock register also holds one bit per slot. When a slot's bit is set, that slot accepts only supervisor-mode requests.

A request that passes both checks goes out on the downstream port. The peripheral's read data then comes back to the requester. A request that fails either check gets an error response, and no downstream strobe is issued for it. Slot 0 holds the gate's own two registers. Software reads and writes them over the same request port, and only supervisor-mode requests may reach them.

The request, downstream and response channels each use valid/ready. The gate handles one transaction at a time. It drops `req_ready` from the cycle after it accepts a request until the requester has taken the response. A source that sees `req_ready` low must keep its request and wait. The downstream peripheral may hold `dn_ready` low for as long as it likes, and the gate keeps `dn_valid` and every downstream field steady until the handshake. The requester may hold `rsp_ready` low for as long as it likes, and the gate keeps the response steady until `rsp_ready` is high.

Top module: `pa_gate`

## Requirements
- R1: The target slot is `req_addr[SLOT_LSB+3:SLOT_LSB]`, with `SLOT_LSB` = 12 by default. Slot 0 is the gate's own register space. Slots 1 to 15 are peripherals.
- R2: Size codes are 0 for byte, 1 for halfword and 2 for word. The default natural width of slot i is the code i mod 3. When width-lock bit i is 1 and the request size differs from the natural width of slot i, the gate returns `rsp_err`=1 and `rsp_rdata`=0, and `dn_valid` never rises for that request.
- R3: When width-lock bit i is 0, a request of any size to slot i is forwarded, unless R4 rejects it.
- R4: When privilege-lock bit i is 1 and `req_super`=0, the request to slot i gets `rsp_err`=1 and `rsp_rdata`=0, and no downstream strobe is issued.
- R5: A forwarded request shows on `dn_addr`, `dn_write`, `dn_size` and `dn_wdata` exactly as it was received. It completes with `rsp_err`=0 and with `rsp_rdata` equal to the `dn_rsp_rdata` returned by the peripheral.
- R6: The width-lock register is at offset 0x0C in slot 0. Bits 15 to 1 are read/write and map to slots 15 to 1. Bit 0 and bits 31 to 16 ignore writes and read as 0.
- R7: The privilege-lock register is at offset 0x00 in slot 0. Bits 15 to 1 are read/write. Bit 0 and bits 31 to 16 ignore writes and read as 1. Any other offset in slot 0 reads as 0 and ignores writes.
- R8: After reset, every read/write bit of both registers is 0. The width-lock register then reads 0x00000000 and the privilege-lock register reads 0xFFFF0001. `req_ready` is 1, and `rsp_valid` and `dn_valid` are 0.
- R9: A slot 0 access with `req_super`=0 returns `rsp_err`=1 and changes no register. A slot 0 write with `req_super`=1 writes all 32 bits of `req_wdata`, whatever the request size.
- R10: Back-pressure rules: the gate accepts a request only while `rsp_valid` is 0 and no downstream transfer is open. It holds `rsp_valid`, `rsp_err` and `rsp_rdata` steady until `rsp_ready`. It holds `dn_valid` and every downstream field steady until `dn_ready`.
- R11: For a slot 0 request and for a rejected request, `rsp_valid` rises in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Gate can accept a request |
| req_addr | input | 24 | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| req_super | input | 1 | 1 when the requester is in supervisor mode |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Peripheral takes the downstream request |
| dn_addr | output | 24 | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Peripheral response valid |
| dn_rsp_rdata | input | 32 | Peripheral read data |

## Verification
The main sweep covers every peripheral slot with every size code in both privilege modes. It repeats under four lock settings: everything clear, every width bit set, every privilege bit set, and two interleaved masks. The interleaved masks show that each bit governs its own slot and not a neighbour. The set-all settings separate the width check from the privilege check. The cleared setting shows that mismatched sizes still pass when no lock applies. The downstream stall length varies from slot to slot. Register readback after all-ones writes shows the fixed bits. User-mode accesses to slot 0 are followed by readback to show that they changed nothing. A held response checks the back-pressure rules.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DNREQ  = 2'd1,
    ST_DNWAIT = 2'd2,
    ST_RSP    = 2'd3
  } gate_state_e;
endpackage

// File: rtl/pa_regs.sv
module pa_regs #(
  parameter int NSLOT    = 16,
  parameter int DW       = 32,
  parameter int OFS_W    = 12,
  parameter int SIZE_OFS = 12'h00C,
  parameter int SUP_OFS  = 12'h000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic [NSLOT-1:0] size_bits,
  output logic [NSLOT-1:0] sup_bits,
  output logic [DW-1:0]    rdata
);
  localparam int PADW = DW - NSLOT;

  logic hit_size, hit_sup;
  assign hit_size = (ofs == OFS_W'(SIZE_OFS));
  assign hit_sup  = (ofs == OFS_W'(SUP_OFS));

  // Bit 0 of each register is fixed; the rest are flops
  assign size_bits[0] = 1'b0;
  assign sup_bits[0]  = 1'b1;

  for (genvar i = 1; i < NSLOT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_bits[i] <= 1'b0;
        sup_bits[i]  <= 1'b0;
      end else if (wr_en) begin
        if (hit_size) size_bits[i] <= wdata[i];
        if (hit_sup)  sup_bits[i]  <= wdata[i];
      end
    end
  end

  always_comb begin
    if (hit_size)     rdata = {{PADW{1'b0}}, size_bits};
    else if (hit_sup) rdata = {{PADW{1'b1}}, sup_bits};
    else              rdata = '0;
  end
endmodule

// File: rtl/pa_check.sv
module pa_check
  import pa_pkg::*;
#(
  parameter int          NSLOT    = 16,
  parameter int          SLOT_W   = 4,
  parameter logic [31:0] SLOT_NAT = 32'h2492_4924
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        size,
  input  logic              super_mode,
  input  logic [NSLOT-1:0]  size_bits,
  input  logic [NSLOT-1:0]  sup_bits,
  output logic              is_reg,
  output logic              reject
);
  logic [NSLOT-1:0] allow;

  // Slot 0 is the gate itself: supervisor only, never width-locked
  assign allow[0] = super_mode;

  for (genvar i = 1; i < NSLOT; i++) begin : g_slot
    logic width_ok, priv_ok;
    assign width_ok = !size_bits[i] || (size == SLOT_NAT[2*i +: 2]);
    assign priv_ok  = !sup_bits[i] || super_mode;
    assign allow[i] = width_ok && priv_ok;
  end

  assign is_reg = (slot == '0);
  assign reject = !allow[slot];
endmodule

// File: rtl/pa_gate.sv
module pa_gate
  import pa_pkg::*;
#(
  parameter int          AW       = 24,
  parameter int          DW       = 32,
  parameter int          SLOT_LSB = 12,
  parameter int          NSLOT    = 16,
  parameter logic [31:0] SLOT_NAT = 32'h2492_4924
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic          req_super,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [AW-1:0] dn_addr,
  output logic          dn_write,
  output logic [1:0]    dn_size,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_rsp_valid,
  input  logic [DW-1:0] dn_rsp_rdata
);
  localparam int SLOT_W = $clog2(NSLOT);

  gate_state_e       state_q;
  logic [SLOT_W-1:0] slot;
  logic [NSLOT-1:0]  size_bits, sup_bits;
  logic [DW-1:0]     reg_rdata;
  logic              is_reg, reject, accept, reg_wr;

  logic [AW-1:0]     addr_q;
  logic              write_q;
  logic [1:0]        size_q;
  logic [DW-1:0]     wdata_q;
  logic              err_q;
  logic [DW-1:0]     rdata_q;

  assign slot      = req_addr[SLOT_LSB +: SLOT_W];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign reg_wr    = accept && is_reg && req_super && req_write;

  pa_check #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .SLOT_NAT(SLOT_NAT)
  ) u_check (
    .slot(slot), .size(req_size), .super_mode(req_super),
    .size_bits(size_bits), .sup_bits(sup_bits),
    .is_reg(is_reg), .reject(reject)
  );

  pa_regs #(
    .NSLOT(NSLOT), .DW(DW), .OFS_W(SLOT_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
    .ofs(req_addr[SLOT_LSB-1:0]), .wdata(req_wdata),
    .size_bits(size_bits), .sup_bits(sup_bits), .rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          write_q <= req_write;
          size_q  <= req_size;
          wdata_q <= req_wdata;
          if (reject) begin
            state_q <= ST_RSP;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else if (is_reg) begin
            state_q <= ST_RSP;
            err_q   <= 1'b0;
            rdata_q <= req_write ? '0 : reg_rdata;
          end else begin
            state_q <= ST_DNREQ;
          end
        end
        ST_DNREQ: if (dn_ready) state_q <= ST_DNWAIT;
        ST_DNWAIT: if (dn_rsp_valid) begin
          state_q <= ST_RSP;
          err_q   <= 1'b0;
          rdata_q <= dn_rsp_rdata;
        end
        ST_RSP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_valid  = (state_q == ST_DNREQ);
  assign dn_addr   = addr_q;
  assign dn_write  = write_q;
  assign dn_size   = size_q;
  assign dn_wdata  = wdata_q;
  assign rsp_valid = (state_q == ST_RSP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/pa_gate_chk.sv
module pa_gate_chk #(
  parameter int AW       = 24,
  parameter int DW       = 32,
  parameter int SLOT_LSB = 12,
  parameter int NSLOT    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic             req_super,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_err,
  input logic [DW-1:0]    rsp_rdata,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [AW-1:0]    dn_addr,
  input logic [1:0]       dn_size,
  input logic [DW-1:0]    dn_wdata,
  input logic [NSLOT-1:0] sup_bits
);
  localparam int SLOT_W = $clog2(NSLOT);

  logic [SLOT_W-1:0] slot;
  logic              acc;
  assign slot = req_addr[SLOT_LSB +: SLOT_W];
  assign acc  = req_valid && req_ready;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err) && $stable(rsp_rdata));

  // R10
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_size) && $stable(dn_wdata));

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || dn_valid) |-> !req_ready);

  // R11
  reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot == '0 |=> rsp_valid);

  // R9
  user_reg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot == '0 && !req_super |=> rsp_valid && rsp_err);

  // R4
  user_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot != '0 && sup_bits[slot] && !req_super |=> rsp_valid && rsp_err && !dn_valid);
endmodule

bind pa_gate pa_gate_chk #(
  .AW(AW), .DW(DW), .SLOT_LSB(SLOT_LSB), .NSLOT(NSLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_super(req_super), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
  .dn_size(dn_size), .dn_wdata(dn_wdata), .sup_bits(sup_bits)
);

// File: tb/pa_gate_test.sv
`timescale 1ns/1ps
module pa_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_super = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [23:0] dn_addr;
  logic        dn_write;
  logic [1:0]  dn_size;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  int checks = 0;
  int failures = 0;
  int stall = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pa_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_super(req_super), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One complete transaction; the bench plays the peripheral.
  task automatic txn(input logic [23:0] a, input logic w, input logic [1:0] sz,
                     input logic sup, input logic [31:0] wd,
                     output logic err, output logic [31:0] rd, output int nstb,
                     output logic [1:0] dsz, output logic [23:0] daddr, output int lat);
    bit hs = 0;
    int cnt = 0;
    nstb = 0; err = 1'bx; rd = 'x; dsz = 'x; daddr = 'x; lat = -1;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_size = sz;
    req_super = sup; req_wdata = wd;
    @(posedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (hs) begin
        dn_ready = 0; dn_rsp_valid = 1; dn_rsp_rdata = {8'h5A, daddr}; hs = 0;
      end else dn_rsp_valid = 0;
      if (dn_valid && !dn_ready) begin
        if (cnt == stall) begin
          dn_ready = 1; hs = 1; nstb++; dsz = dn_size; daddr = dn_addr;
        end else cnt++;
      end
      if (rsp_valid) begin
        err = rsp_err; rd = rsp_rdata; lat = i;
        break;
      end
    end
    @(posedge clk);
  endtask

  logic        e;
  logic [31:0] d;
  int          n, l;
  logic [1:0]  ds;
  logic [23:0] da;

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state at the ports
    chk("R8 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R8 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R8 dn_valid", {31'b0, dn_valid}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    txn(24'h00000C, 0, 2, 1, 0, e, d, n, ds, da, l);
    chk("R8 width reg reset", d, 32'h0000_0000);
    chk("R11 reg latency", l, 0);
    txn(24'h000000, 0, 2, 1, 0, e, d, n, ds, da, l);
    chk("R8 priv reg reset", d, 32'hFFFF_0001);

    // R6 / R7 fixed bits
    txn(24'h00000C, 1, 0, 1, 32'hFFFF_FFFF, e, d, n, ds, da, l);
    txn(24'h00000C, 0, 2, 1, 0, e, d, n, ds, da, l);
    chk("R6 width reg fixed bits", d, 32'h0000_FFFE);
    txn(24'h000000, 1, 2, 1, 32'h0000_0000, e, d, n, ds, da, l);
    txn(24'h000000, 0, 2, 1, 0, e, d, n, ds, da, l);
    chk("R7 priv reg fixed bits", d, 32'hFFFF_0001);
    txn(24'h000008, 1, 2, 1, 32'hFFFF_FFFF, e, d, n, ds, da, l);
    txn(24'h000008, 0, 2, 1, 0, e, d, n, ds, da, l);
    chk("R7 other offset reads zero", d, 32'h0);
    chk("R1 slot 0 no downstream", n, 0);

    // R9 user access to slot 0
    txn(24'h00000C, 1, 2, 0, 32'h0, e, d, n, ds, da, l);
    chk("R9 user write err", {31'b0, e}, 32'd1);
    chk("R11 reject latency", l, 0);
    txn(24'h00000C, 0, 2, 1, 0, e, d, n, ds, da, l);
    chk("R9 user write ignored", d, 32'h0000_FFFE);
    txn(24'h00000C, 0, 2, 0, 0, e, d, n, ds, da, l);
    chk("R9 user read err", {31'b0, e}, 32'd1);
    chk("R9 user read data", d, 32'h0);

    // Main sweep
    for (int c = 0; c < 4; c++) begin
      logic [15:0] szv, spv;
      case (c)
        0: begin szv = 16'h0000; spv = 16'h0000; end
        1: begin szv = 16'hFFFF; spv = 16'h0000; end
        2: begin szv = 16'h0000; spv = 16'hFFFF; end
        default: begin szv = 16'h5A5A; spv = 16'hA5A5; end
      endcase
      txn(24'h00000C, 1, 2, 1, {16'h0, szv}, e, d, n, ds, da, l);
      txn(24'h000000, 1, 2, 1, {16'h0, spv}, e, d, n, ds, da, l);
      txn(24'h00000C, 0, 2, 1, 0, e, d, n, ds, da, l);
      chk("R6 width readback", d, {16'h0, szv[15:1], 1'b0});
      txn(24'h000000, 0, 2, 1, 0, e, d, n, ds, da, l);
      chk("R7 priv readback", d, {16'hFFFF, spv[15:1], 1'b1});
      for (int s = 1; s < 16; s++) begin
        for (int sz = 0; sz < 3; sz++) begin
          for (int sup = 0; sup < 2; sup++) begin
            logic [23:0] a;
            bit wrej, prej, rej;
            a = 24'(s << 12) | 24'h040 | 24'(sz * 4);
            stall = s % 3;
            wrej = szv[s] && (sz != s % 3);
            prej = spv[s] && (sup == 0);
            rej = wrej || prej;
            txn(a, sz[0], 2'(sz), sup[0], 32'h1234_0000 | 32'(s), e, d, n, ds, da, l);
            if (rej) begin
              chk(wrej ? "R2 reject err" : "R4 reject err", {31'b0, e}, 32'd1);
              chk(wrej ? "R2 no strobe" : "R4 no strobe", n, 0);
              chk("R2 reject data", d, 32'h0);
            end else begin
              chk("R3 forward err", {31'b0, e}, 32'd0);
              chk("R3 one strobe", n, 1);
              chk("R5 dn size", {30'b0, ds}, 32'(sz));
              chk("R1 R5 dn addr", {8'h0, da}, {8'h0, a});
              chk("R5 rdata", d, {8'h5A, a});
            end
          end
        end
      end
    end

    // R10 held response
    stall = 0;
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_addr = 24'h000000; req_write = 0; req_size = 2; req_super = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    chk("R10 rsp held", {31'b0, rsp_valid}, 32'd1);
    chk("R10 busy ready low", {31'b0, req_ready}, 32'd0);
    chk("R10 held data", rsp_rdata, 32'hFFFF_A5A5);
    rsp_ready = 1;
    @(negedge clk);
    chk("R10 rsp released", {31'b0, rsp_valid}, 32'd0);
    chk("R10 ready again", {31'b0, req_ready}, 32'd1);

    done = 1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule